// File: doc/BRIEF.md
# Card-Detect Status and Interrupt Register Block

A small memory-mapped control block for a platform's peripheral area. It answers a word-addressed register bus with a fixed identification word and a fixed decode-configuration word. It also provides one interrupt register that combines two kinds of bit. One bit mirrors the live level of a memory-card write-protect switch. The other bit is sticky and captures a card-insertion event. The sticky bit drives an interrupt line until software clears it by writing a one to that bit position.

Software reads the identification word to find the block, and polls or takes the interrupt when a card is inserted. It then writes the clear pattern to acknowledge the event. The flash-programming word and the decode word sit in the map so that software can touch them, but writes to them have no effect. Any access outside the four mapped words returns zero and raises a one-cycle error pulse.

Top module: `cardctl_regs`

## Requirements
- R1: A read (bus_sel=1, bus_wr=0) is accepted on a rising edge, and bus_rdata shows the result from that edge onward. bus_rdata holds its value until the next accepted read, and writes or idle cycles do not change it.
- R2: A read of word 0 returns 0x41034003.
- R3: A read of word 1 returns 0x00000000, and a read of word 3 returns 0x00000011.
- R4: In a read of word 2, bit 0 equals the wprot level sampled on the accepting edge. Every bit other than bits 0 and 3 reads zero.
- R5: Bit 3 of word 2 is set on the first rising edge where cardin is high. It stays set after cardin falls, until it is cleared as in R6.
- R6: A write to word 2 with data bit 3 set clears bit 3 on that edge. A write to word 2 with data bit 3 clear changes nothing, and no write to word 2 changes bit 0.
- R7: card_irq always equals the current value of bit 3, so it rises on the edge that sets the latch and falls on the edge that clears it.
- R8: When cardin is high on the same edge as a clearing write to word 2, the set wins and bit 3 remains 1.
- R9: Writes to words 0, 1 and 3 are accepted without error and have no effect. Later reads of those words and of bit 3 are unchanged.
- R10: An access, read or write, to any word address of 4 or above makes bus_err high for exactly the one cycle after the accepting edge. A read there returns zero. Mapped accesses and idle cycles leave bus_err low.
- R11: While the reset is asserted, and until its synchronized release, card_irq, bus_err and bus_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access strobe, one access per cycle in which it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped word |
| wprot | input | 1 | Card write-protect level, synchronous to clk |
| cardin | input | 1 | Card-insertion indication, synchronous to clk |
| card_irq | output | 1 | Interrupt, equal to the sticky card-insert bit |

## Verification
The card-insert input can rise in the same cycle as a software write that clears the sticky bit. The two then compete for one flip-flop. The bench drives cardin high during the clearing write to word 2. It expects card_irq to stay high on the next cycle and a following read to show bit 3 still set. A clear with cardin low, and a clear whose data lacks bit 3, are run next to that case to show that only the coincidence keeps the bit set.

// File: rtl/cardctl_pkg.sv
package cardctl_pkg;

  // Word map: the low two address bits select one of four words.
  typedef enum logic [1:0] {
    WORD_IDENT = 2'd0,
    WORD_FLASH = 2'd1,
    WORD_EVENT = 2'd2,
    WORD_DECOD = 2'd3
  } word_e;

  localparam int unsigned MAP_BITS  = 2;
  localparam logic [31:0] IDENT_VAL = 32'h4103_4003;
  localparam logic [31:0] DECOD_VAL = 32'h0000_0011;

  // Bit positions inside the event word, decoded by software.
  localparam int unsigned WP_POS = 0;
  localparam int unsigned CD_POS = 3;

  typedef struct packed {
    logic  rd_hit;
    logic  rd_miss;
    logic  wr_miss;
    logic  clr_wr;
    word_e word;
  } access_t;

endpackage

// File: rtl/cardctl_rst_sync.sv
module cardctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/cardctl_decode.sv
module cardctl_decode
  import cardctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr_bit,
  output access_t           acc
);

  logic mapped;
  logic rd;
  logic wrt;

  generate
    if (ADDR_W > MAP_BITS) begin : g_upper
      assign mapped = (addr[ADDR_W-1:MAP_BITS] == '0);
    end else begin : g_flat
      assign mapped = 1'b1;
    end
  endgenerate

  always_comb begin
    rd          = sel && !wr;
    wrt         = sel && wr;
    acc.word    = word_e'(addr[MAP_BITS-1:0]);
    acc.rd_hit  = rd && mapped;
    acc.rd_miss = rd && !mapped;
    acc.wr_miss = wrt && !mapped;
    acc.clr_wr  = wrt && mapped && (acc.word == WORD_EVENT) && clr_bit;
  end

endmodule

// File: rtl/cardctl_card_latch.sv
module cardctl_card_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_in,
  input  logic clr_req,
  output logic flag
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // Set dominates clear; enable only when the state can move.
  always_comb begin
    flag_en = set_in || clr_req;
    flag_d  = set_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_CARD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_in |=> flag); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_in && clr_req) |=> flag); // R8

  AST_CARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag); // R5

  AST_CARD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_in) |=> !flag); // R6

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set_in) |=> !flag); // R5

endmodule

// File: rtl/cardctl_readmux.sv
module cardctl_readmux
  import cardctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  word_e             word,
  input  logic              wp_level,
  input  logic              cd_flag,
  output logic [DATA_W-1:0] value
);

  always_comb begin
    value = '0;
    unique case (word)
      WORD_IDENT: value = DATA_W'(IDENT_VAL);
      WORD_FLASH: value = '0;
      WORD_EVENT: begin
        value[WP_POS] = wp_level;
        value[CD_POS] = cd_flag;
      end
      WORD_DECOD: value = DATA_W'(DECOD_VAL);
      default:    value = '0;
    endcase
  end

endmodule

// File: rtl/cardctl_regs.sv
module cardctl_regs
  import cardctl_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              wprot,
  input  logic              cardin,
  output logic              card_irq
);

  localparam logic [ADDR_W-1:0] IDENT_ADDR = ADDR_W'(0);

  logic              srst_n;
  access_t           acc;
  logic              cd_flag;
  logic [DATA_W-1:0] mux_val;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic              rdata_en;
  logic              err_q;
  logic              err_d;
  logic              unused_wdata;

  assign unused_wdata = ^{bus_wdata[DATA_W-1:CD_POS+1], bus_wdata[CD_POS-1:0]};

  cardctl_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cardctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .clr_bit (bus_wdata[CD_POS]),
    .acc     (acc)
  );

  cardctl_card_latch u_latch (
    .clk     (clk),
    .rst_n   (srst_n),
    .set_in  (cardin),
    .clr_req (acc.clr_wr),
    .flag    (cd_flag)
  );

  cardctl_readmux #(.DATA_W(DATA_W)) u_mux (
    .word     (acc.word),
    .wp_level (wprot),
    .cd_flag  (cd_flag),
    .value    (mux_val)
  );

  // Next-state for the read-data and error registers.
  always_comb begin
    rdata_en = acc.rd_hit || acc.rd_miss;
    rdata_d  = acc.rd_hit ? mux_val : '0;
    err_d    = acc.rd_miss || acc.wr_miss;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign card_irq  = cd_flag;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R1

  AST_IDENT_READ: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && !bus_wr && bus_addr == IDENT_ADDR) |=> (bus_rdata == DATA_W'(IDENT_VAL))); // R2

  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && bus_addr[ADDR_W-1:MAP_BITS] != '0) |=> bus_err); // R10

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_sel && bus_addr[ADDR_W-1:MAP_BITS] != '0) |=> !bus_err); // R10

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && !bus_wr && bus_addr[ADDR_W-1:MAP_BITS] != '0) |=> (bus_rdata == '0)); // R10

  AST_RESET_QUIET: assert property (@(posedge clk)
    !srst_n |-> (!card_irq && !bus_err && bus_rdata == '0)); // R11

endmodule

// File: tb/cardctl_regs_test.sv
module cardctl_regs_test;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int K_RDATA = 0;
  localparam int K_IRQ   = 1;
  localparam int K_ERR   = 2;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] val;
    string       tag;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          wprot;
  logic          cardin;
  logic          card_irq;

  int       cyc = 0;
  int       n_chk = 0;
  int       n_fail = 0;
  sb_item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cardctl_regs #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .wprot(wprot), .cardin(cardin), .card_irq(card_irq)
  );

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  function automatic void push(int kind, logic [31:0] val, string tag);
    sb_item_t it;
    it.due  = cyc + 1;
    it.kind = kind;
    it.val  = val;
    it.tag  = tag;
    sb.push_back(it);
  endfunction

  // Monitor: compares outputs away from the active edge.
  always @(negedge clk) begin
    sb_item_t it;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      case (it.kind)
        K_RDATA: chk({it.tag, " rdata"}, bus_rdata, it.val);
        K_IRQ:   chk({it.tag, " card_irq"}, {31'd0, card_irq}, it.val);
        default: chk({it.tag, " bus_err"}, {31'd0, bus_err}, it.val);
      endcase
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    push(K_ERR, 0, tag);
    tick();
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    push(K_RDATA, exp, tag);
    push(K_ERR, (a > 3) ? 32'd1 : 32'd0, tag);
    tick();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, string tag);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    push(K_ERR, (a > 3) ? 32'd1 : 32'd0, tag);
    tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; wprot = 1'b0; cardin = 1'b0;
    tick(); tick();
    // R11: quiet outputs under reset, even with cardin high
    cardin = 1'b1;
    tick();
    chk("R11 reset", {31'd0, card_irq}, 0);
    chk("R11 reset", {31'd0, bus_err}, 0);
    chk("R11 reset", bus_rdata, 0);
    cardin = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R11 after release", {31'd0, card_irq}, 0);

    // R2, R3: fixed words
    rd(0, 32'h4103_4003, "R2 ident");
    rd(1, 32'h0, "R3 flash word");
    rd(3, 32'h11, "R3 decode word");
    idle("R1 idle");
    // R1: rdata holds after idle and write cycles
    push(K_RDATA, 32'h11, "R1 hold idle");
    idle("R1 idle");
    wr(1, 32'hFFFF_FFFF, "R1 write");
    push(K_RDATA, 32'h11, "R1 hold after write");
    idle("R1 idle");

    // R4: write-protect level mirrored
    wprot = 1'b1;
    rd(2, 32'h1, "R4 wprot high");
    wprot = 1'b0;
    rd(2, 32'h0, "R4 wprot low");
    idle("R4 idle");

    // R5, R7: one-cycle card pulse latches and raises card_irq
    cardin = 1'b1;
    push(K_IRQ, 1, "R7 irq rises");
    tick();
    cardin = 1'b0;
    push(K_IRQ, 1, "R5 sticky");
    tick();
    repeat (3) tick();
    rd(2, 32'h8, "R5 bit3 held");

    // R6: clear needs data bit 3
    wr(2, 32'h0000_0001, "R6 no clear");
    push(K_IRQ, 1, "R6 irq stays");
    rd(2, 32'h8, "R6 bit3 kept");
    wprot = 1'b1;
    wr(2, 32'hFFFF_FFFF, "R6 clear");
    push(K_IRQ, 0, "R7 irq falls");
    rd(2, 32'h1, "R6 bit0 untouched");
    idle("R6 idle");

    // R8: set and clear on the same edge
    cardin = 1'b1;
    wr(2, 32'h8, "R8 clash");
    push(K_IRQ, 1, "R8 set wins");
    cardin = 1'b0;
    rd(2, 32'h9, "R8 bit3 set");
    idle("R8 idle");

    // R9: writes to read-only words ignored
    wr(0, 32'h0, "R9 write ident");
    wr(1, 32'hFFFF_FFFF, "R9 write flash");
    wr(3, 32'h0, "R9 write decode");
    push(K_IRQ, 1, "R9 latch untouched");
    rd(0, 32'h4103_4003, "R9 ident");
    rd(1, 32'h0, "R9 flash");
    rd(3, 32'h11, "R9 decode");

    // R10: unmapped accesses
    rd(5, 32'h0, "R10 miss read");
    idle("R10 pulse ends");
    wr(15, 32'hFFFF_FFFF, "R10 miss write");
    push(K_IRQ, 1, "R10 latch untouched");
    rd(4, 32'h0, "R10 miss read2");
    rd(2, 32'h9, "R10 event word after miss");
    idle("R10 idle");
    wprot = 1'b0;
    wr(2, 32'h8, "R6 final clear");
    push(K_IRQ, 0, "R6 final irq");
    idle("R6 idle");
    repeat (3) tick();

    summary();
    $finish;
  end

endmodule